// File: doc/BRIEF.md
# Instruction Pair Fusion Detector

This block sits after a decode stage that presents two consecutive 32-bit instruction words per cycle (an older slot and a younger slot). It tests whether the pair can be merged into a single macro-operation. Three pair kinds are recognised:

- **Carry-add:** a register add, then an unsigned set-less-than that recomputes the carry out of that add.
- **Multiply:** an upper-half multiply, then the lower-half multiply on the same sources.
- **Divide:** a divide, then the remainder on the same sources with the same signedness.

The verdict is registered and leaves the block on a valid/ready output port. It carries a fuse flag, a two-bit kind code, and four register indices. Execution units downstream use these to issue one operation where two would otherwise go.

Fusion is optional. Any pair that fails a pattern or a safety condition is reported as unfused, and the instructions proceed individually. Examples of failed safety conditions:

- The first instruction's destination clobbers a source that the second instruction still needs.
- The sum is discarded into the zero register.

The output stage is a two-state machine:

| State | Meaning |
|---|---|
| `ST_EMPTY` | No result is held. |
| `ST_FULL` | A result is waiting downstream. |

| Transition | Condition |
|---|---|
| `ST_EMPTY`→`ST_FULL` | A pair is accepted. |
| `ST_FULL`→`ST_FULL` | The held result is taken and a new pair is accepted in the same cycle, or downstream is stalled. |
| `ST_FULL`→`ST_EMPTY` | The held result is taken and no pair arrives. |

Top module: `fuse_pair_detect`

## Requirements
- R1: The bench uses this field layout: opcode in bits [6:0], destination in [11:7], funct3 in [14:12], first source in [19:15], second source in [24:20], funct7 in [31:25]. Register instructions use opcode 0110011. add is funct3 000 with funct7 0000000, and sltu is funct3 011 with funct7 0000000. Given `add rdl,rs1,rs2` followed by `sltu rdh,rdl,rs2`, the block reports fuse=1 and kind=01. Any other funct7 on the add (such as 0100000), or an sltu whose first source is not rdl, gives no fusion.
- R2: A carry-add pair whose sltu compares against the add's first source (`sltu rdh,rdl,rs1`) also fuses with kind=01. This includes the case where rs1 equals rdl and the sltu compares against rs2.
- R3: A carry-add pair does not fuse if the sltu's compared register equals rdl, or if rdl is x0.
- R4: The upper-half multiplies all use funct7 0000001. They are MULH (funct3 001), MULHSU (010) and MULHU (011). Any of them followed by MUL (funct7 0000001, funct3 000) with the same rs1 and the same rs2 fuses with kind=10. Swapped or different sources do not fuse.
- R5: A multiply or divide pair does not fuse when the first instruction's destination equals its rs1 or its rs2.
- R6: DIV (funct7 0000001, funct3 100) followed by REM (110) fuses with kind=11 when both use the same sources. DIVU (101) followed by REMU (111) also fuses. Mixed signedness (DIV with REMU, DIVU with REM) does not fuse.
- R7: A pair is considered for fusion only when both slot valid bits are high. A slot whose low two bits are not 11 (a compressed instruction) never fuses.
- R8: An unfused result has fuse=0, kind=00 and all four register index outputs at zero.
- R9: A fused result carries these register indices:

  | Output | Contents |
  |---|---|
  | `rd_a` | Older instruction's destination |
  | `rd_b` | Younger instruction's destination |
  | `rs_a` | Older instruction's first source |
  | `rs_b` | Older instruction's second source |

- R10: A pair accepted at a clock edge (pair_valid and pair_ready both high) appears on the outputs with out_valid high right after that edge. pair_ready is high whenever the output is empty or out_ready is high.
- R11: While out_valid is high and out_ready is low, all outputs hold their values and pair_ready stays low, so no new pair is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pair_valid_i | input | 1 | A pair is presented |
| pair_ready_o | output | 1 | Pair is accepted this cycle |
| slot0_vld_i | input | 1 | Older slot holds an instruction |
| slot1_vld_i | input | 1 | Younger slot holds an instruction |
| slot0_insn_i | input | 32 | Older instruction word |
| slot1_insn_i | input | 32 | Younger instruction word |
| out_valid_o | output | 1 | Result is held |
| out_ready_i | input | 1 | Downstream takes the result |
| fuse_o | output | 1 | Pair fuses |
| kind_o | output | 2 | 00 none, 01 carry-add, 10 multiply, 11 divide |
| rd_a_o | output | 5 | Older destination |
| rd_b_o | output | 5 | Younger destination |
| rs_a_o | output | 5 | Older first source |
| rs_b_o | output | 5 | Older second source |

## Verification
The bench targets three kinds of carry-add corner case:

- The sltu comparing against either add operand. A design matching only one order would miss half of the real carry idioms.
- An add whose first source is also its destination. A design that compares against the overwritten register would fuse a pair whose carry reads a destroyed value.
- A zero destination, which would fuse a sum that is never written.

For multiply and divide, swapped sources, a destination equal to a source, and mixed divide signedness are each presented. A design that misses any of these would merge instructions whose results differ from running them separately.

A downstream stall with a second pair waiting shows whether the held result is corrupted or a pair is lost or taken twice.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
    localparam int ILEN  = 32;
    localparam int REGW  = 5;
    localparam logic [6:0] OPC_REG  = 7'b0110011;
    localparam logic [6:0] F7_BASE  = 7'b0000000;
    localparam logic [6:0] F7_MEXT  = 7'b0000001;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_CADD = 2'b01,
        KIND_MULP = 2'b10,
        KIND_DIVP = 2'b11
    } fuse_kind_e;

    typedef struct packed {
        logic [REGW-1:0] rd;
        logic [REGW-1:0] rs1;
        logic [REGW-1:0] rs2;
        logic            is_add;
        logic            is_sltu;
        logic            is_mulh;
        logic            is_mul;
        logic            is_div;
        logic            is_rem;
        logic            uns;
    } slot_t;

    typedef struct packed {
        logic            fuse;
        fuse_kind_e      kind;
        logic [REGW-1:0] rd_a;
        logic [REGW-1:0] rd_b;
        logic [REGW-1:0] rs_a;
        logic [REGW-1:0] rs_b;
    } verdict_t;
endpackage

// File: rtl/fuse_slot_decode.sv
module fuse_slot_decode
    import fuse_pkg::*;
(
    input  logic [ILEN-1:0] insn_i,
    input  logic            valid_i,
    output slot_t           slot_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic       reg_op;
    logic       base_op;
    logic       mext_op;

    always_comb begin
        opc     = insn_i[6:0];
        f3      = insn_i[14:12];
        f7      = insn_i[31:25];
        // a compressed word has low bits other than 11 and is rejected here
        reg_op  = valid_i && (insn_i[1:0] == 2'b11) && (opc == OPC_REG);
        base_op = reg_op && (f7 == F7_BASE);
        mext_op = reg_op && (f7 == F7_MEXT);

        slot_o.rd      = insn_i[11:7];
        slot_o.rs1     = insn_i[19:15];
        slot_o.rs2     = insn_i[24:20];
        slot_o.is_add  = base_op && (f3 == 3'b000);
        slot_o.is_sltu = base_op && (f3 == 3'b011);
        slot_o.is_mul  = mext_op && (f3 == 3'b000);
        slot_o.is_mulh = mext_op && (f3[2] == 1'b0) && (f3[1:0] != 2'b00);
        slot_o.is_div  = mext_op && (f3[2:1] == 2'b10);
        slot_o.is_rem  = mext_op && (f3[2:1] == 2'b11);
        slot_o.uns     = f3[0];
    end
endmodule

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
    import fuse_pkg::*;
(
    input  slot_t    older_i,
    input  slot_t    younger_i,
    output verdict_t verdict_o
);
    logic cmp_ok;
    logic cadd_hit;
    logic same_src;
    logic dest_clear;
    logic mul_hit;
    logic div_hit;

    always_comb begin
        // compared operand must be an add source that survived the add
        cmp_ok   = ((younger_i.rs2 == older_i.rs1) || (younger_i.rs2 == older_i.rs2))
                   && (younger_i.rs2 != older_i.rd);
        cadd_hit = older_i.is_add && younger_i.is_sltu && (older_i.rd != '0)
                   && (younger_i.rs1 == older_i.rd) && cmp_ok;

        same_src   = (younger_i.rs1 == older_i.rs1) && (younger_i.rs2 == older_i.rs2);
        dest_clear = (older_i.rd != older_i.rs1) && (older_i.rd != older_i.rs2);
        mul_hit    = older_i.is_mulh && younger_i.is_mul && same_src && dest_clear;
        div_hit    = older_i.is_div && younger_i.is_rem && (older_i.uns == younger_i.uns)
                     && same_src && dest_clear;

        verdict_o = '0;
        if (cadd_hit || mul_hit || div_hit) begin
            verdict_o.fuse = 1'b1;
            verdict_o.rd_a = older_i.rd;
            verdict_o.rd_b = younger_i.rd;
            verdict_o.rs_a = older_i.rs1;
            verdict_o.rs_b = older_i.rs2;
            if (cadd_hit)     verdict_o.kind = KIND_CADD;
            else if (mul_hit) verdict_o.kind = KIND_MULP;
            else              verdict_o.kind = KIND_DIVP;
        end
    end
endmodule

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
    import fuse_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pair_valid_i,
    output logic             pair_ready_o,
    input  logic             slot0_vld_i,
    input  logic             slot1_vld_i,
    input  logic [ILEN-1:0]  slot0_insn_i,
    input  logic [ILEN-1:0]  slot1_insn_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic             fuse_o,
    output logic [1:0]       kind_o,
    output logic [REGW-1:0]  rd_a_o,
    output logic [REGW-1:0]  rd_b_o,
    output logic [REGW-1:0]  rs_a_o,
    output logic [REGW-1:0]  rs_b_o
);
    localparam int NSLOT = 2;

    typedef enum logic {ST_EMPTY, ST_FULL} ost_e;

    ost_e            state_q, state_d;
    verdict_t        held_q, comb_v;
    slot_t           slots   [NSLOT];
    logic [ILEN-1:0] insns   [NSLOT];
    logic            slot_ok;
    logic            accept;

    always_comb begin
        insns[0] = slot0_insn_i;
        insns[1] = slot1_insn_i;
        slot_ok  = slot0_vld_i && slot1_vld_i;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_dec
        fuse_slot_decode u_dec (
            .insn_i  (insns[g]),
            .valid_i (slot_ok),
            .slot_o  (slots[g])
        );
    end

    fuse_pair_match u_match (
        .older_i   (slots[0]),
        .younger_i (slots[1]),
        .verdict_o (comb_v)
    );

    assign pair_ready_o = (state_q == ST_EMPTY) || out_ready_i;
    assign accept       = pair_valid_i && pair_ready_o;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (out_ready_i && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_EMPTY;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)     held_q <= '0;
        else if (accept) held_q <= comb_v;
    end

    always_comb begin
        out_valid_o = (state_q == ST_FULL);
        fuse_o      = held_q.fuse;
        kind_o      = held_q.kind;
        rd_a_o      = held_q.rd_a;
        rd_b_o      = held_q.rd_b;
        rs_a_o      = held_q.rs_a;
        rs_b_o      = held_q.rs_b;
    end

    AST_ACCEPT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pair_valid_i && pair_ready_o) |=> out_valid_o); // R10
    AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |-> !pair_ready_o); // R11
    AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(fuse_o) && $stable(kind_o)
        && $stable(rd_a_o) && $stable(rd_b_o) && $stable(rs_a_o) && $stable(rs_b_o))); // R11
    AST_CADD_DEST_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && fuse_o && kind_o == 2'b01) |-> (rd_a_o != '0)); // R3
    AST_MULDIV_SRC_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && fuse_o && kind_o[1]) |-> (rd_a_o != rs_a_o && rd_a_o != rs_b_o)); // R5
    AST_UNFUSED_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !fuse_o) |-> (kind_o == 2'b00 && rd_a_o == '0 && rd_b_o == '0
        && rs_a_o == '0 && rs_b_o == '0)); // R8
endmodule

// File: tb/fuse_pair_detect_tb.sv
module fuse_pair_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pair_valid = 1'b0;
    logic        pair_ready;
    logic        v0 = 1'b0, v1 = 1'b0;
    logic [31:0] i0 = '0, i1 = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        fuse;
    logic [1:0]  kind;
    logic [4:0]  rd_a, rd_b, rs_a, rs_b;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic       fuse;
        logic [1:0] kind;
        logic [4:0] ra, rb, sa, sb;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    fuse_pair_detect dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .pair_valid_i(pair_valid), .pair_ready_o(pair_ready),
        .slot0_vld_i(v0), .slot1_vld_i(v1),
        .slot0_insn_i(i0), .slot1_insn_i(i1),
        .out_valid_o(out_valid), .out_ready_i(out_ready),
        .fuse_o(fuse), .kind_o(kind),
        .rd_a_o(rd_a), .rd_b_o(rd_b), .rs_a_o(rs_a), .rs_b_o(rs_b)
    );

    function automatic logic [31:0] rt(input logic [6:0] f7, input int rs2, input int rs1,
                                       input logic [2:0] f3, input int rd);
        return {f7, rs2[4:0], rs1[4:0], f3, rd[4:0], 7'b0110011};
    endfunction

    task automatic check(input bit ok, input string req, input string act, input string expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", req, act, expv);
        end
    endtask

    // monitor: pops an expected item at every output handshake
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && out_valid && out_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected output", "none");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({fuse, kind, rd_a, rd_b, rs_a, rs_b} ==
                          {e.fuse, e.kind, e.ra, e.rb, e.sa, e.sb}, e.req,
                          $sformatf("f=%0d k=%0d %0d/%0d/%0d/%0d", fuse, kind, rd_a, rd_b, rs_a, rs_b),
                          $sformatf("f=%0d k=%0d %0d/%0d/%0d/%0d", e.fuse, e.kind, e.ra, e.rb, e.sa, e.sb));
                end
            end
        end
    end

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic va, input logic vb,
                        input logic f, input logic [1:0] k, input int ra, input int rb,
                        input int sa, input int sbv, input string req);
        exp_t e;
        @(negedge clk);
        i0 = a; i1 = b; v0 = va; v1 = vb; pair_valid = 1'b1;
        #1;
        while (!pair_ready) begin
            @(negedge clk);
            #1;
        end
        e.fuse = f; e.kind = k; e.ra = ra[4:0]; e.rb = rb[4:0]; e.sa = sa[4:0]; e.sb = sbv[4:0];
        e.req = req;
        sb_q.push_back(e);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        pair_valid = 1'b0;
    endtask

    localparam logic [6:0] B = 7'b0000000;
    localparam logic [6:0] M = 7'b0000001;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && pair_ready, "R10", $sformatf("v=%0d r=%0d", out_valid, pair_ready), "v=0 r=1");

        // R1: compare against rs2
        send(rt(B,13,12,3'b000,10), rt(B,13,10,3'b011,11), 1,1, 1,2'b01,10,11,12,13, "R1 R9");
        // R2: compare against rs1
        send(rt(B,7,6,3'b000,5), rt(B,6,5,3'b011,8), 1,1, 1,2'b01,5,8,6,7, "R2");
        // R2: rs1 equals rdl, compare against rs2
        send(rt(B,12,10,3'b000,10), rt(B,12,10,3'b011,11), 1,1, 1,2'b01,10,11,10,12, "R2");
        // R3: compared register is rdl
        send(rt(B,12,10,3'b000,10), rt(B,10,10,3'b011,11), 1,1, 0,2'b00,0,0,0,0, "R3 R8");
        // R3: rdl is x0
        send(rt(B,2,1,3'b000,0), rt(B,1,0,3'b011,3), 1,1, 0,2'b00,0,0,0,0, "R3");
        // R1: operands of sltu swapped
        send(rt(B,13,12,3'b000,10), rt(B,10,13,3'b011,11), 1,1, 0,2'b00,0,0,0,0, "R1");
        // R1: sub instead of add
        send(rt(7'b0100000,13,12,3'b000,10), rt(B,13,10,3'b011,11), 1,1, 0,2'b00,0,0,0,0, "R1");
        // R4: the three upper-half forms
        send(rt(M,7,6,3'b001,5), rt(M,7,6,3'b000,8), 1,1, 1,2'b10,5,8,6,7, "R4 R9");
        send(rt(M,7,6,3'b010,5), rt(M,7,6,3'b000,8), 1,1, 1,2'b10,5,8,6,7, "R4");
        send(rt(M,3,4,3'b011,9), rt(M,3,4,3'b000,1), 1,1, 1,2'b10,9,1,4,3, "R4");
        // R4: swapped sources
        send(rt(M,7,6,3'b011,5), rt(M,6,7,3'b000,8), 1,1, 0,2'b00,0,0,0,0, "R4");
        // R5: multiply destination overwrites rs1
        send(rt(M,7,6,3'b001,6), rt(M,7,6,3'b000,8), 1,1, 0,2'b00,0,0,0,0, "R5");
        // R6: signed and unsigned divide pairs
        send(rt(M,22,21,3'b100,20), rt(M,22,21,3'b110,23), 1,1, 1,2'b11,20,23,21,22, "R6 R9");
        send(rt(M,22,21,3'b101,20), rt(M,22,21,3'b111,23), 1,1, 1,2'b11,20,23,21,22, "R6");
        // R6: mixed signedness
        send(rt(M,22,21,3'b100,20), rt(M,22,21,3'b111,23), 1,1, 0,2'b00,0,0,0,0, "R6");
        send(rt(M,22,21,3'b101,20), rt(M,22,21,3'b110,23), 1,1, 0,2'b00,0,0,0,0, "R6");
        // R5: divide destination overwrites rs2
        send(rt(M,22,21,3'b101,22), rt(M,22,21,3'b111,23), 1,1, 0,2'b00,0,0,0,0, "R5");
        // R7: younger slot invalid, then compressed older slot
        send(rt(M,7,6,3'b001,5), rt(M,7,6,3'b000,8), 1,0, 0,2'b00,0,0,0,0, "R7");
        send({rt(B,13,12,3'b000,10)} & 32'hFFFF_FFFC | 32'h1, rt(B,13,10,3'b011,11), 1,1,
             0,2'b00,0,0,0,0, "R7");
        idle();

        // R11: stall with a second pair waiting
        @(negedge clk);
        out_ready = 1'b0;
        send(rt(M,7,6,3'b001,5), rt(M,7,6,3'b000,8), 1,1, 1,2'b10,5,8,6,7, "R11");
        @(negedge clk);
        i0 = rt(M,22,21,3'b100,20); i1 = rt(M,22,21,3'b110,23); pair_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #1;
            check(out_valid && !pair_ready && kind == 2'b10 && rd_a == 5'd5 && rd_b == 5'd8,
                  "R11", $sformatf("v=%0d r=%0d k=%0d ra=%0d", out_valid, pair_ready, kind, rd_a),
                  "v=1 r=0 k=2 ra=5");
            @(negedge clk);
        end
        begin
            exp_t e2;
            e2.fuse = 1; e2.kind = 2'b11; e2.ra = 20; e2.rb = 23; e2.sa = 21; e2.sb = 22; e2.req = "R11 R10";
            sb_q.push_back(e2);
        end
        out_ready = 1'b1;
        @(negedge clk);
        pair_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0 && !out_valid, "R10", $sformatf("left=%0d v=%0d", sb_q.size(), out_valid),
              "left=0 v=0");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule